// File: doc/BRIEF.md
# Table-Driven Programmable Sequence Generator

This block steps through a sequence that software or a controller writes into two small tables instead of into fixed logic. A state register holds the current step. On every clock it loads its next value from a transition table. That table is indexed by the current state joined with a few external condition bits. Because of this, the walk through the states can be linear, can jump anywhere, or can branch on the inputs.

A second table maps each state to an output word. Several states may therefore share the same output value. Both tables are filled through one synchronous write port. A select bit chooses which table a write goes to.

A typical use is to program the tables while reset is held and then release reset. Unused states should be pointed back at a known state so that the machine cannot get stuck in them. Entries can also be rewritten while the machine runs. A rewritten entry steers every lookup made after the write edge.

Top module: `seqgen_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `state_o` becomes 0 whatever the tables hold.
- R2: At every rising edge with `rst` low, `state_o` loads the transition-table entry at address `{state_o, ext_in}`. The state forms the high bits of the address and the inputs form the low bits. No increment is applied.
- R3: The transition table can encode jumps that are not sequential. For example, state 2 goes to 4, state 4 goes to 1, and state 1 returns to 2, all taken one per clock.
- R4: A state that lies outside the programmed cycle can be given a recovery entry to 0. Once the machine enters that state, it returns to 0 on the next clock and continues the cycle.
- R5: A custom count of 0, 1, 2, 3, 4, 5, 6 followed by a jump to 10 is produced through the same load path.
- R6: The value of `ext_in` selects between different successor entries of the same state, so the machine can branch on the inputs.
- R7: `out_val` always shows the output-table entry for the current `state_o`. Distinct states may hold equal values. For example, a 6-state cycle can produce 0, 1, 1, 3, 2, 2.
- R8: A write with `wr_en` high and `wr_sel` = 0 stores `wr_data[ST_W-1:0]` at transition address `wr_addr`. A write with `wr_sel` = 1 stores `wr_data[OUT_W-1:0]` at output address `wr_addr[ST_W-1:0]`. The state load at the write edge itself uses the old content. The new content is used from the next edge onward.
- R9: While `wr_en` is low, `wr_sel`, `wr_addr` and `wr_data` have no effect on either table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the state register |
| ext_in | input | IN_W (1 if IN_W=0) | Condition bits joined to the state to form the table address |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | Write target: 0 transition table, 1 output table |
| wr_addr | input | ST_W+IN_W | Write address (low ST_W bits for the output table) |
| wr_data | input | max(ST_W,OUT_W) | Write data |
| state_o | output | ST_W | Current state |
| out_val | output | OUT_W | Output word mapped from the current state |

## Verification
The assertions check two things on every cycle. First, the register always takes the word the transition table presents, and it is zero right after reset. Second, neither the presented table word nor the output word can change unless their address moved or a write was strobed. Whether particular graphs are reproduced — the jump chain, the count that leaps to 10, recovery out of an unused state, branching on an input, and repeated output values — is shown only by the bench. The bench programs each graph and follows it transition by transition. It also checks the ordering of a write against the load at the same edge.

// File: rtl/seqgen_pkg.sv
package seqgen_pkg;
   function automatic int sg_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   typedef enum logic {
      SEL_NEXT = 1'b0,
      SEL_OUT  = 1'b1
   } seqgen_sel_e;
endpackage

// File: rtl/seqgen_table.sv
module seqgen_table #(
   parameter int AW = 4,
   parameter int DW = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("seqgen_table: AW out of range");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/seqgen_state_reg.sv
module seqgen_state_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= ld_val;
   end
endmodule

// File: rtl/seqgen_top.sv
module seqgen_top
   import seqgen_pkg::*;
#(
   parameter int ST_W  = 4,
   parameter int IN_W  = 1,
   parameter int OUT_W = 4
) (
   input  logic                                  clk,
   input  logic                                  rst,
   input  logic [((IN_W > 0) ? IN_W : 1)-1:0]    ext_in,
   input  logic                                  wr_en,
   input  logic                                  wr_sel,
   input  logic [ST_W+IN_W-1:0]                  wr_addr,
   input  logic [sg_max(ST_W, OUT_W)-1:0]        wr_data,
   output logic [ST_W-1:0]                       state_o,
   output logic [OUT_W-1:0]                      out_val
);
   localparam int AW    = ST_W + IN_W;
   localparam int IN_PW = (IN_W > 0) ? IN_W : 1;

   generate
      if (ST_W < 1)  begin : g_bad_st  $error("seqgen_top: ST_W must be >= 1"); end
      if (IN_W < 0)  begin : g_bad_in  $error("seqgen_top: IN_W must be >= 0"); end
      if (OUT_W < 1) begin : g_bad_out $error("seqgen_top: OUT_W must be >= 1"); end
      if (AW > 12)   begin : g_bad_aw  $error("seqgen_top: table too deep"); end
   endgenerate

   logic [AW-1:0]   nxt_addr;
   logic [ST_W-1:0] nxt_rd;
   logic [ST_W-1:0] state_q;
   logic            we_nxt;
   logic            we_out;

   assign we_nxt = wr_en && (seqgen_sel_e'(wr_sel) == SEL_NEXT);
   assign we_out = wr_en && (seqgen_sel_e'(wr_sel) == SEL_OUT);

   generate
      if (IN_W > 0) begin : g_addr_in
         assign nxt_addr = {state_q, ext_in};
      end else begin : g_addr_plain
         logic unused_in;
         assign unused_in = ^ext_in;
         assign nxt_addr  = state_q;
      end
   endgenerate

   seqgen_table #(.AW(AW), .DW(ST_W)) u_next_tbl (
      .clk   (clk),
      .we    (we_nxt),
      .waddr (wr_addr),
      .wdata (wr_data[ST_W-1:0]),
      .raddr (nxt_addr),
      .rdata (nxt_rd)
   );

   seqgen_table #(.AW(ST_W), .DW(OUT_W)) u_out_tbl (
      .clk   (clk),
      .we    (we_out),
      .waddr (wr_addr[ST_W-1:0]),
      .wdata (wr_data[OUT_W-1:0]),
      .raddr (state_q),
      .rdata (out_val)
   );

   seqgen_state_reg #(.W(ST_W)) u_state (
      .clk    (clk),
      .rst    (rst),
      .ld_val (nxt_rd),
      .q      (state_q)
   );

   assign state_o = state_q;

   logic unused_pw;
   assign unused_pw = (IN_PW > 0);
endmodule

// File: rtl/seqgen_chk.sv
module seqgen_chk #(
   parameter int ST_W  = 4,
   parameter int OUT_W = 4,
   parameter int AW    = 5
) (
   input logic            clk,
   input logic            rst,
   input logic [ST_W-1:0] state_o,
   input logic [OUT_W-1:0] out_val,
   input logic            wr_en,
   input logic            wr_sel,
   input logic [AW-1:0]   nxt_addr,
   input logic [ST_W-1:0] nxt_rd
);
   // R1
   reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (state_o == '0));

   // R2
   load_from_table_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (state_o == $past(nxt_rd)));

   // R9
   table_word_steady_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(nxt_addr) && !$past(wr_en)) |-> $stable(nxt_rd));

   // R7
   out_word_steady_chk: assert property (@(posedge clk) disable iff (rst)
      ($stable(state_o) && !$past(wr_en && wr_sel)) |-> $stable(out_val));
endmodule

bind seqgen_top seqgen_chk #(.ST_W(ST_W), .OUT_W(OUT_W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .state_o  (state_o),
   .out_val  (out_val),
   .wr_en    (wr_en),
   .wr_sel   (wr_sel),
   .nxt_addr (nxt_addr),
   .nxt_rd   (nxt_rd)
);

// File: tb/test_seqgen_top.sv
`timescale 1ns/1ps
module test_seqgen_top;
   localparam int ST_W = 4;
   localparam int IN_W = 1;
   localparam int OUT_W = 4;
   localparam int AW = ST_W + IN_W;
   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst;
   logic [IN_W-1:0] ext_in;
   logic wr_en, wr_sel;
   logic [AW-1:0] wr_addr;
   logic [DW-1:0] wr_data;
   logic [ST_W-1:0] state_o;
   logic [OUT_W-1:0] out_val;

   int n_chk = 0;
   int n_fail = 0;
   logic [ST_W-1:0]  m_nxt [1 << AW];
   logic [OUT_W-1:0] m_out [1 << ST_W];
   logic [ST_W-1:0]  m_state = '0;

   always #2.5 clk = ~clk;

   seqgen_top #(.ST_W(ST_W), .IN_W(IN_W), .OUT_W(OUT_W)) i_seqgen_top (
      .clk(clk), .rst(rst), .ext_in(ext_in), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_addr(wr_addr), .wr_data(wr_data), .state_o(state_o), .out_val(out_val)
   );

   function automatic logic [ST_W-1:0] f_next(input logic [ST_W-1:0] s, input logic [IN_W-1:0] i);
      return m_nxt[{s, i}];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic r, input logic [IN_W-1:0] i, input logic we,
                      input logic sel, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input string tag);
      @(negedge clk);
      rst = r; ext_in = i; wr_en = we; wr_sel = sel; wr_addr = a; wr_data = d;
      @(posedge clk);
      m_state = r ? '0 : f_next(m_state, i);
      if (we && !sel) m_nxt[a] = d[ST_W-1:0];
      if (we && sel)  m_out[a[ST_W-1:0]] = d[OUT_W-1:0];
      #1;
      if (r) chk(state_o == '0, "R1 reset state", int'(state_o), 0);
      else begin
         chk(state_o == m_state, tag, int'(state_o), int'(m_state));
         chk(out_val == m_out[m_state], "R7 output map", int'(out_val), int'(m_out[m_state]));
      end
   endtask

   task automatic wr_next(input logic [ST_W-1:0] s, input logic [IN_W-1:0] i, input logic [ST_W-1:0] n);
      cyc(1'b1, '0, 1'b1, 1'b0, {s, i}, DW'(n), "R8 write");
   endtask

   task automatic wr_both(input logic [ST_W-1:0] s, input logic [ST_W-1:0] n);
      wr_next(s, 1'b0, n);
      wr_next(s, 1'b1, n);
   endtask

   task automatic wr_outv(input logic [ST_W-1:0] s, input logic [OUT_W-1:0] v);
      cyc(1'b1, '0, 1'b1, 1'b1, AW'(s), DW'(v), "R8 write");
   endtask

   task automatic all_to_zero();
      for (int s = 0; s < (1 << ST_W); s++) wr_both(ST_W'(s), '0);
   endtask

   task automatic run(input int n, input logic [IN_W-1:0] i, input string tag);
      for (int k = 0; k < n; k++) cyc(1'b0, i, 1'b0, 1'b0, '0, '0, tag);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      rst = 1'b1; ext_in = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_addr = '0; wr_data = '0;
      // R1: random tables, then check reset still gives state 0
      for (int a = 0; a < (1 << AW); a++) cyc(1'b1, '0, 1'b1, 1'b0, AW'(a), DW'($urandom), "R1 fill");
      for (int s = 0; s < (1 << ST_W); s++) cyc(1'b1, '0, 1'b1, 1'b1, AW'(s), DW'($urandom), "R1 fill");
      chk(state_o == '0, "R1 reset with random tables", int'(state_o), 0);
      run(6, 1'b0, "R2 random graph walk");

      // R3: jump chain 0->2->4->1->2
      all_to_zero();
      wr_both(4'd0, 4'd2); wr_both(4'd2, 4'd4); wr_both(4'd4, 4'd1); wr_both(4'd1, 4'd2);
      for (int s = 0; s < 16; s++) wr_outv(ST_W'(s), OUT_W'(s));
      cyc(1'b1, '0, 1'b0, 1'b0, '0, '0, "R1");
      run(10, 1'b0, "R3 jump chain");
      chk(state_o == 4'd4 || state_o == 4'd1 || state_o == 4'd2, "R3 in chain", int'(state_o), 2);

      // R5: 0..6 then 10, 10 -> 0
      all_to_zero();
      for (int s = 0; s < 6; s++) wr_both(ST_W'(s), ST_W'(s + 1));
      wr_both(4'd6, 4'd10);
      cyc(1'b1, '0, 1'b0, 1'b0, '0, '0, "R1");
      for (int s = 1; s <= 6; s++) begin
         cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R5 custom count");
         chk(state_o == ST_W'(s), "R5 count step", int'(state_o), s);
      end
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R5 jump");
      chk(state_o == 4'd10, "R5 jump to 10", int'(state_o), 10);
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R5 wrap");
      chk(state_o == 4'd0, "R5 wrap to 0", int'(state_o), 0);

      // R4 + R6: 0..6 cycle; in=1 at state 3 diverts to unused 15, 15 recovers to 0
      all_to_zero();
      for (int s = 0; s < 6; s++) wr_both(ST_W'(s), ST_W'(s + 1));
      wr_next(4'd3, 1'b1, 4'd15);
      cyc(1'b1, '0, 1'b0, 1'b0, '0, '0, "R1");
      run(3, 1'b0, "R6 walk");
      cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R6 branch in=0");
      chk(state_o == 4'd4, "R6 in=0 successor", int'(state_o), 4);
      run(4, 1'b0, "R4 cycle");
      chk(state_o == 4'd1, "R4 cycle wrap", int'(state_o), 1);
      run(2, 1'b0, "R6 walk");
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R6 branch in=1");
      chk(state_o == 4'd15, "R6 in=1 successor", int'(state_o), 15);
      cyc(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R4 recovery");
      chk(state_o == 4'd0, "R4 recovery to 0", int'(state_o), 0);
      run(7, 1'b0, "R4 resumed cycle");

      // R7: 6-state cycle output 0,1,1,3,2,2
      all_to_zero();
      for (int s = 0; s < 5; s++) wr_both(ST_W'(s), ST_W'(s + 1));
      wr_outv(4'd0, 4'd0); wr_outv(4'd1, 4'd1); wr_outv(4'd2, 4'd1);
      wr_outv(4'd3, 4'd3); wr_outv(4'd4, 4'd2); wr_outv(4'd5, 4'd2);
      cyc(1'b1, '0, 1'b0, 1'b0, '0, '0, "R1");
      chk(out_val == 4'd0, "R7 pattern step 0", int'(out_val), 0);
      run(12, 1'b0, "R7 repeating outputs");

      // R8: write the entry being looked up at this very edge
      cyc(1'b0, 1'b0, 1'b1, 1'b0, {m_state, 1'b0}, 4'd9, "R8 old entry at write edge");
      // R9: disabled write strobe with junk data
      cyc(1'b0, 1'b0, 1'b0, 1'b0, {m_state, 1'b0}, 4'd13, "R9 ignored write");
      cyc(1'b0, 1'b0, 1'b0, 1'b1, AW'(m_state), 4'd15, "R9 ignored out write");

      // R2 / R8 / R9: random mix
      for (int k = 0; k < 400; k++)
         cyc(($urandom % 50) == 0, IN_W'($urandom), ($urandom % 4) == 0, 1'(($urandom)),
             AW'($urandom), DW'($urandom), "R2 random transition");

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule